// File: doc/BRIEF.md
# Compressed Branch Trace Encoder

This block sits beside a processor core and turns each taken branch into a compact trace packet. The core presents a branch event with the 32-bit destination, the 32-bit source and a 4-bit compensation value. The encoder compares both addresses with the destination it sent most recently. It keeps only the low nibbles that differ, at a granularity of 4, 8, 16 or 32 bits, so packets range from 5 to 19 nibbles.

Finished packets are held in a small packet FIFO. A serializer drains the FIFO as a stream of 4-bit nibbles. A valid strobe marks every nibble and a sync strobe marks the first nibble of each packet. When the FIFO has no room, a mode input selects the response. In stall mode the core waits on a ready signal. In drop mode the event is discarded, a sticky overflow flag is raised, and compression restarts from full-width addresses.

Top module: `brtrace_packer`

## Requirements
- R1: After synchronous reset, trc_valid and trc_sync are low, ovf_flag is low and ev_ready is high.
- R2: No nibble is emitted unless a branch event was accepted; with the FIFO drained, trc_valid stays low.
- R3: Each packet is emitted in this order: a command nibble 4'b0010 carrying trc_sync; a size nibble whose bits [1:0] are the destination size code and bits [3:2] the source size code (00=4, 01=8, 10=16, 11=32 bits); the destination nibbles, least significant first; the source nibbles, least significant first; one compensation nibble. trc_sync is high only on the command nibble.
- R4: The first packet after reset uses size code 11 for both addresses.
- R5: When history is valid, the destination size is 4 bits if bits [31:4] equal the stored destination, else 8 bits if [31:8] match, else 16 bits if [31:16] match, else 32 bits.
- R6: The source size uses the same priority rule, compared against the stored destination and not against the previous source.
- R7: Every accepted event loads the stored destination with its own destination and marks the history valid.
- R8: With drop_mode low, ev_ready is low while the packet FIFO is full; an event held during that time is accepted later without loss or change.
- R9: With drop_mode high, an event presented while ev_ready is low is discarded, ovf_flag becomes set and stays set, and the next accepted packet uses size code 11 for both addresses.
- R10: ovf_flag never becomes set while drop_mode is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drop_mode | input | 1 | 1: discard events when full; 0: stall the core |
| ev_valid | input | 1 | Branch event present |
| ev_dest | input | 32 | Branch destination address |
| ev_src | input | 32 | Branch source address |
| ev_comp | input | 4 | Source compensation value |
| ev_ready | output | 1 | Packet FIFO has room for one more packet |
| trc_data | output | 4 | Trace nibble |
| trc_sync | output | 1 | First nibble of a packet |
| trc_valid | output | 1 | trc_data carries a nibble |
| ovf_flag | output | 1 | Sticky: a packet was discarded |

## Verification
The checker verifies on every cycle that sync only comes with valid and always carries the branch command, that the reset state is clean, that the overflow flag is sticky, that it rises after any drop and never rises in stall mode, and that a drop clears the history. The bench sweeps all sixteen destination and source size combinations over several boundary bit positions. It also covers stall and drop bursts, and it compares every streamed nibble against an arithmetic model. Only the stream comparison can show the nibble ordering, the width selection against the previous destination, and loss-free stalling.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int ADDR_W   = 32;
  localparam int NIB_W    = 4;
  localparam int PKT_NIBS = 2 + 2 * (ADDR_W / NIB_W) + 1;
  localparam int PKT_W    = PKT_NIBS * NIB_W;
  localparam int LEN_W    = $clog2(PKT_NIBS + 1);
  localparam logic [NIB_W-1:0] CMD_BRANCH = 4'b0010;

  typedef enum logic [1:0] {
    SZ_4  = 2'b00,
    SZ_8  = 2'b01,
    SZ_16 = 2'b10,
    SZ_32 = 2'b11
  } sz_e;

  function automatic int unsigned nib_cnt(sz_e s);
    return 32'd1 << s;
  endfunction

  function automatic logic [ADDR_W-1:0] keep_mask(sz_e s);
    case (s)
      SZ_4:    return 32'h0000_000F;
      SZ_8:    return 32'h0000_00FF;
      SZ_16:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/brt_size_sel.sv
module brt_size_sel
  import brt_pkg::*;
(
  input  logic              hist_ok,
  input  logic [ADDR_W-1:0] last_dest,
  input  logic [ADDR_W-1:0] cur,
  output sz_e               code
);
  always_comb begin
    if (!hist_ok)                         code = SZ_32;
    else if (last_dest[31:4]  == cur[31:4])  code = SZ_4;
    else if (last_dest[31:8]  == cur[31:8])  code = SZ_8;
    else if (last_dest[31:16] == cur[31:16]) code = SZ_16;
    else                                  code = SZ_32;
  end
endmodule

// File: rtl/brt_pkt_build.sv
module brt_pkt_build
  import brt_pkg::*;
(
  input  logic [ADDR_W-1:0] dest,
  input  logic [ADDR_W-1:0] src,
  input  logic [NIB_W-1:0]  comp,
  input  sz_e               dcode,
  input  sz_e               scode,
  output logic [PKT_W-1:0]  payload,
  output logic [LEN_W-1:0]  len
);
  int unsigned dn, sn;

  always_comb begin
    dn = nib_cnt(dcode);
    sn = nib_cnt(scode);
    payload = '0;
    payload[3:0] = CMD_BRANCH;
    payload[7:4] = {scode, dcode};
    payload = payload | (PKT_W'(dest & keep_mask(dcode)) << 8);
    payload = payload | (PKT_W'(src & keep_mask(scode)) << (8 + 4 * dn));
    payload = payload | (PKT_W'(comp) << (8 + 4 * (dn + sn)));
    len = LEN_W'(3 + dn + sn);
  end
endmodule

// File: rtl/brt_pkt_fifo.sv
module brt_pkt_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 81
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
    if (pop)  rdata     <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/brt_nibble_tx.sv
module brt_nibble_tx
  import brt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_empty,
  input  logic [PKT_W-1:0] pkt_data,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             pop,
  output logic [NIB_W-1:0] trc_data,
  output logic             trc_sync,
  output logic             trc_valid
);
  logic [PKT_W-1:0] shreg;
  logic [LEN_W-1:0] left;
  logic             pend, first;

  assign pop = (left == '0) && !pend && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      left      <= '0;
      pend      <= 1'b0;
      first     <= 1'b0;
      trc_data  <= '0;
      trc_sync  <= 1'b0;
      trc_valid <= 1'b0;
    end else begin
      pend      <= pop;
      trc_valid <= 1'b0;
      trc_sync  <= 1'b0;
      if (pend) begin
        shreg <= pkt_data;
        left  <= pkt_len;
        first <= 1'b1;
      end else if (left != '0) begin
        trc_data  <= shreg[NIB_W-1:0];
        trc_valid <= 1'b1;
        trc_sync  <= first;
        first     <= 1'b0;
        shreg     <= shreg >> NIB_W;
        left      <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/brtrace_packer.sv
module brtrace_packer
  import brt_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drop_mode,
  input  logic              ev_valid,
  input  logic [31:0]       ev_dest,
  input  logic [31:0]       ev_src,
  input  logic [3:0]        ev_comp,
  output logic              ev_ready,
  output logic [3:0]        trc_data,
  output logic              trc_sync,
  output logic              trc_valid,
  output logic              ovf_flag
);
  localparam int ENT_W = PKT_W + LEN_W;

  logic              hist_valid;
  logic [ADDR_W-1:0] last_dest;
  sz_e               dcode, scode;
  logic [PKT_W-1:0]  enc_pkt;
  logic [LEN_W-1:0]  enc_len;
  logic [ENT_W-1:0]  rd_ent;
  logic              full, empty, pop, accept, drop;

  assign ev_ready = !full;
  assign accept   = ev_valid && !full;
  assign drop     = ev_valid && full && drop_mode;

  brt_size_sel u_dsel (.hist_ok(hist_valid), .last_dest(last_dest), .cur(ev_dest), .code(dcode));
  brt_size_sel u_ssel (.hist_ok(hist_valid), .last_dest(last_dest), .cur(ev_src),  .code(scode));

  brt_pkt_build u_build (
    .dest(ev_dest), .src(ev_src), .comp(ev_comp),
    .dcode(dcode), .scode(scode),
    .payload(enc_pkt), .len(enc_len)
  );

  brt_pkt_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk(clk), .rst(rst),
    .push(accept), .wdata({enc_len, enc_pkt}),
    .pop(pop), .rdata(rd_ent),
    .full(full), .empty(empty)
  );

  brt_nibble_tx u_tx (
    .clk(clk), .rst(rst), .fifo_empty(empty),
    .pkt_data(rd_ent[PKT_W-1:0]), .pkt_len(rd_ent[ENT_W-1:PKT_W]),
    .pop(pop), .trc_data(trc_data), .trc_sync(trc_sync), .trc_valid(trc_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_valid <= 1'b0;
      last_dest  <= '0;
      ovf_flag   <= 1'b0;
    end else begin
      if (accept) begin
        last_dest  <= ev_dest;
        hist_valid <= 1'b1;
      end else if (drop) begin
        hist_valid <= 1'b0;
      end
      if (drop) ovf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/brtrace_packer_chk.sv
module brtrace_packer_chk (
  input logic       clk,
  input logic       rst,
  input logic       drop_mode,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic [3:0] trc_data,
  input logic       trc_sync,
  input logic       trc_valid,
  input logic       ovf_flag,
  input logic       hist_valid
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!trc_valid && !trc_sync && !ovf_flag && ev_ready));

  assert_sync_with_valid_R3: assert property (@(posedge clk) disable iff (rst)
    trc_sync |-> trc_valid);

  assert_sync_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    trc_sync |-> (trc_data == 4'b0010));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  assert_drop_sets_ovf_R9: assert property (@(posedge clk) disable iff (rst)
    (drop_mode && ev_valid && !ev_ready) |=> ovf_flag);

  assert_drop_clears_hist_R9: assert property (@(posedge clk) disable iff (rst)
    (drop_mode && ev_valid && !ev_ready) |=> !hist_valid);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (!drop_mode && !ovf_flag) |=> !ovf_flag);

  assert_accept_sets_hist_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready) |=> hist_valid);
endmodule

bind brtrace_packer brtrace_packer_chk u_chk (
  .clk(clk), .rst(rst), .drop_mode(drop_mode), .ev_valid(ev_valid),
  .ev_ready(ev_ready), .trc_data(trc_data), .trc_sync(trc_sync),
  .trc_valid(trc_valid), .ovf_flag(ovf_flag), .hist_valid(hist_valid)
);

// File: tb/brtrace_packer_test.sv
module brtrace_packer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        drop_mode = 1'b0;
  logic        ev_valid = 1'b0;
  logic [31:0] ev_dest = '0;
  logic [31:0] ev_src = '0;
  logic [3:0]  ev_comp = '0;
  logic        ev_ready;
  logic [3:0]  trc_data;
  logic        trc_sync, trc_valid, ovf_flag;

  always #5 clk = ~clk;

  brtrace_packer uut (
    .clk(clk), .rst(rst), .drop_mode(drop_mode), .ev_valid(ev_valid),
    .ev_dest(ev_dest), .ev_src(ev_src), .ev_comp(ev_comp), .ev_ready(ev_ready),
    .trc_data(trc_data), .trc_sync(trc_sync), .trc_valid(trc_valid), .ovf_flag(ovf_flag)
  );

  int total = 0, bad = 0, stalls = 0, drops = 0;
  bit done = 0, post_drop = 0;
  logic [31:0] prev_m = '0;
  bit hist_m = 0;
  logic [4:0] expq[$];
  string tagq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] pick(input bit hv, input logic [31:0] ref_a,
                                      input logic [31:0] cur);
    if (!hv) return 2'd3;
    if (ref_a[31:4] == cur[31:4]) return 2'd0;
    if (ref_a[31:8] == cur[31:8]) return 2'd1;
    if (ref_a[31:16] == cur[31:16]) return 2'd2;
    return 2'd3;
  endfunction

  task automatic model_push(input logic [31:0] d, input logic [31:0] s, input logic [3:0] c);
    logic [1:0] dc, sc;
    string stag;
    dc = pick(hist_m, prev_m, d);
    sc = pick(hist_m, prev_m, s);
    stag = post_drop ? "R9" : (hist_m ? "R5 R6" : "R4");
    expq.push_back({1'b1, 4'b0010}); tagq.push_back("R3");
    expq.push_back({1'b0, sc, dc});  tagq.push_back(stag);
    for (int i = 0; i < (1 << dc); i++) begin
      expq.push_back({1'b0, d[4*i +: 4]}); tagq.push_back("R7");
    end
    for (int i = 0; i < (1 << sc); i++) begin
      expq.push_back({1'b0, s[4*i +: 4]}); tagq.push_back("R6");
    end
    expq.push_back({1'b0, c}); tagq.push_back("R3");
    prev_m = d;
    hist_m = 1;
    post_drop = 0;
  endtask

  task automatic post(input logic [31:0] d, input logic [31:0] s, input logic [3:0] c);
    @(negedge clk);
    ev_dest = d; ev_src = s; ev_comp = c; ev_valid = 1'b1;
    if (!drop_mode)
      while (!ev_ready) begin
        stalls++;
        @(negedge clk);
      end
    if (ev_ready) model_push(d, s, c);
    else begin
      drops++;
      hist_m = 0;
      post_drop = 1;
    end
    @(posedge clk);
    #1 ev_valid = 1'b0;
  endtask

  task automatic wait_drain;
    for (int i = 0; i < 4000 && expq.size() != 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (trc_sync && !trc_valid) chk(0, "R3", "sync without valid", 1, 0);
      if (trc_valid) begin
        if (expq.size() == 0) chk(0, "R2", "unexpected nibble", {27'd0, trc_sync, trc_data}, 0);
        else begin
          logic [4:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk({trc_sync, trc_data} == e, t, "nibble {sync,data}",
              {27'd0, trc_sync, trc_data}, {27'd0, e});
        end
      end
    end
  end

  function automatic logic [31:0] vary(input logic [1:0] code, input int k);
    case (code)
      2'd0: return 32'(k % 16);
      2'd1: return 32'h10 << (k % 4);
      2'd2: return 32'h100 << (k % 8);
      default: return 32'h1_0000 << (k % 16);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "R2", "watchdog expired", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(trc_valid == 0, "R1", "trc_valid after reset", {31'd0, trc_valid}, 0);
    chk(trc_sync == 0, "R1", "trc_sync after reset", {31'd0, trc_sync}, 0);
    chk(ovf_flag == 0, "R1", "ovf_flag after reset", {31'd0, ovf_flag}, 0);
    chk(ev_ready == 1, "R1", "ev_ready after reset", {31'd0, ev_ready}, 1);

    // R4: first packet after reset is full width both ways
    post(32'h1234_5678, 32'h1234_5670, 4'h3);
    // R5 R6: sweep every destination/source size pair over boundary bits
    for (int k = 0; k < 3; k++)
      for (int dc = 0; dc < 4; dc++)
        for (int sc = 0; sc < 4; sc++) begin
          logic [31:0] d, s;
          d = prev_m ^ vary(2'(dc), k * 5 + sc);
          s = prev_m ^ vary(2'(sc), k * 3 + dc + 1) ^ 32'(k);
          post(d, s, 4'(dc * 4 + sc + k));
        end
    wait_drain();
    chk(expq.size() == 0, "R8", "all stalled packets delivered", expq.size(), 0);
    chk(stalls > 0, "R8", "stall observed in burst", stalls, 1);
    chk(ovf_flag == 0, "R10", "no overflow in stall mode", {31'd0, ovf_flag}, 0);

    // R2: idle with no events, stream stays quiet (collector flags any nibble)
    repeat (40) @(negedge clk);
    chk(trc_valid == 0, "R2", "idle output", {31'd0, trc_valid}, 0);

    // R9: drop mode burst
    drop_mode = 1'b1;
    for (int i = 0; i < 10; i++)
      post(32'hA000_0000 + 32'(i) * 32'h0101_0110, 32'h5000_0000 + 32'(i) * 32'h0011_0101, 4'(i));
    @(negedge clk);
    chk(drops > 0, "R9", "drops happened", drops, 1);
    chk(ovf_flag == 1, "R9", "overflow set", {31'd0, ovf_flag}, 1);
    wait_drain();
    post(32'hA000_0004, 32'hA000_0008, 4'h9);
    post(32'hA000_0014, 32'hA000_1100, 4'hA);
    wait_drain();
    chk(ovf_flag == 1, "R9", "overflow sticky", {31'd0, ovf_flag}, 1);
    chk(expq.size() == 0, "R9", "kept packets delivered", expq.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule